// File: doc/BRIEF.md
# Round-Robin Transmit Line Scanner

This block decides which of several transmit lines the controller serves next. On every periodic tick, while the controller's scan enable is on and no line is currently reported ready, it searches the line-enable mask for a line that can take a character. The search starts at the line after the one it served last and wraps around. The first enabled line it meets is latched as the reported line, the ready flag is set, and an interrupt request is raised if transmit interrupts are enabled. All candidates are examined in the same cycle.

Software or the surrounding controller clears the ready flag when it writes new transmit control or a data character. The scanner then resumes from the line it just reported. A tick that finds a ready line uses up that tick's interrupt opportunity. For that reason the block also outputs a per-tick slot flag, which tells the receive side whether it may evaluate and signal its own status in that tick.

Top module: `lsc_tx_scanner`

## Requirements
- R1: After reset, `tx_ready_o`, `tx_irq_o` and `tx_line_o` are all zero, and the next search starts at line 1.
- R2: `tx_ready_o` is set only on the edge after a cycle in which `tick_i` and `scan_en_i` were high, `rdy_clr_i` was low and `tx_ready_o` was low. A clear in the same cycle as a tick therefore blocks that tick's search.
- R3: A search tests lines in the order last+1, last+2, ..., wrapping modulo NUM_LINES and ending with the last served line itself. It reports on `tx_line_o` the first line whose bit in `line_en_i` is 1.
- R4: A search that finds no enabled line leaves `tx_ready_o` low and `tx_line_o` unchanged.
- R5: While `tx_ready_o` stays high, `tx_line_o` does not change, and ticks have no effect on it.
- R6: On the edge that sets `tx_ready_o`, `tx_irq_o` takes the value that `tx_int_en_i` had in the cycle of the search.
- R7: A cycle with `rdy_clr_i` high clears `tx_ready_o` and `tx_irq_o` on the next edge and leaves `tx_line_o` unchanged.
- R8: A cycle with `scan_en_i` low clears `tx_ready_o` and `tx_irq_o` on the next edge and starts no search.
- R9: `rx_slot_o` is high in a cycle exactly when `tick_i` is high and that tick's search does not set `tx_ready_o`. It is combinational.
- R10: `tx_irq_o` is never high while `tx_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Periodic scan strobe, one cycle wide |
| scan_en_i | input | 1 | Master scan enable |
| tx_int_en_i | input | 1 | Transmit interrupt enable |
| line_en_i | input | NUM_LINES | Per-line transmit enable, bit n for line n |
| rdy_clr_i | input | 1 | Clears ready and interrupt (control or data write) |
| tx_ready_o | output | 1 | A line has been selected and awaits a character |
| tx_line_o | output | LINE_W | Number of the selected line |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_slot_o | output | 1 | This tick is free for receive-status evaluation |

## Verification
The bench builds the block with its defaults: four lines and the rotate-and-encode search variant. With four lines, a random 4-bit enable mask can place the nearest enabled line at any wrap distance from the last served line, including the case where that line is the only candidate left. Directed sequences add the empty mask, a clear that coincides with a tick, and scan enable dropping while a line is ready. The walking-search variant is chosen by a parameter and is not built by this bench.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   typedef enum logic [0:0] {
      PICK_ROTATE = 1'b0,
      PICK_WALK   = 1'b1
   } pick_style_e;

   function automatic bit lsc_is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/lsc_pick.sv
module lsc_pick
   import lsc_pkg::*;
#(
   parameter int          NUM_LINES = 4,
   parameter pick_style_e STYLE     = PICK_ROTATE,
   localparam int         LINE_W    = $clog2(NUM_LINES)
) (
   input  logic [LINE_W-1:0]    start_i,
   input  logic [NUM_LINES-1:0] en_i,
   output logic                 hit_o,
   output logic [LINE_W-1:0]    idx_o
);

   generate
      if (!lsc_is_pow2(NUM_LINES)) begin : g_bad_lines
         $error("lsc_pick: NUM_LINES must be a power of two of at least 2");
      end

      if (STYLE == PICK_ROTATE) begin : g_rotate
         logic [NUM_LINES-1:0] rot;
         logic [LINE_W-1:0]    ofs;
         always_comb begin
            rot = (en_i >> start_i) | (en_i << (NUM_LINES - int'(start_i)));
            ofs = '0;
            for (int j = NUM_LINES - 1; j >= 0; j--) begin
               if (rot[j]) ofs = LINE_W'(j);
            end
            hit_o = |rot;
            idx_o = start_i + ofs;
         end
      end else begin : g_walk
         logic [LINE_W-1:0] cand;
         always_comb begin
            hit_o = 1'b0;
            idx_o = '0;
            cand  = '0;
            for (int i = 0; i < NUM_LINES; i++) begin
               cand = start_i + LINE_W'(i);
               if (!hit_o && en_i[cand]) begin
                  hit_o = 1'b1;
                  idx_o = cand;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lsc_state.sv
module lsc_state #(
   parameter int  NUM_LINES = 4,
   localparam int LINE_W    = $clog2(NUM_LINES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scan_go_i,
   input  logic              hit_i,
   input  logic [LINE_W-1:0] hit_idx_i,
   input  logic              clr_i,
   input  logic              int_en_i,
   output logic              ready_o,
   output logic              irq_o,
   output logic [LINE_W-1:0] last_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ready_o <= 1'b0;
         irq_o   <= 1'b0;
         last_o  <= '0;
      end else if (clr_i) begin
         ready_o <= 1'b0;
         irq_o   <= 1'b0;
      end else if (scan_go_i && hit_i) begin
         ready_o <= 1'b1;
         irq_o   <= int_en_i;
         last_o  <= hit_idx_i;
      end
   end

   // R5: the served line holds while ready stays set
   p_line_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && $past(ready_o)) |-> $stable(last_o));

   // R10: no interrupt request without ready
   p_irq_needs_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ready_o);

endmodule

// File: rtl/lsc_tx_scanner.sv
module lsc_tx_scanner
   import lsc_pkg::*;
#(
   parameter int          NUM_LINES = 4,
   parameter pick_style_e STYLE     = PICK_ROTATE,
   localparam int         LINE_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic                 scan_en_i,
   input  logic                 tx_int_en_i,
   input  logic [NUM_LINES-1:0] line_en_i,
   input  logic                 rdy_clr_i,
   output logic                 tx_ready_o,
   output logic [LINE_W-1:0]    tx_line_o,
   output logic                 tx_irq_o,
   output logic                 rx_slot_o
);

   logic              scan_go;
   logic              hit;
   logic [LINE_W-1:0] hit_idx;
   logic [LINE_W-1:0] start;
   logic              clr;

   assign start   = tx_line_o + LINE_W'(1);
   assign scan_go = tick_i && scan_en_i && !tx_ready_o && !rdy_clr_i;
   assign clr     = rdy_clr_i || !scan_en_i;
   assign rx_slot_o = tick_i && !(scan_go && hit);

   lsc_pick #(
      .NUM_LINES (NUM_LINES),
      .STYLE     (STYLE)
   ) i_pick (
      .start_i (start),
      .en_i    (line_en_i),
      .hit_o   (hit),
      .idx_o   (hit_idx)
   );

   lsc_state #(
      .NUM_LINES (NUM_LINES)
   ) i_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .scan_go_i (scan_go),
      .hit_i     (hit),
      .hit_idx_i (hit_idx),
      .clr_i     (clr),
      .int_en_i  (tx_int_en_i),
      .ready_o   (tx_ready_o),
      .irq_o     (tx_irq_o),
      .last_o    (tx_line_o)
   );

   // checker-only copy of the enable mask of the previous cycle
   logic [NUM_LINES-1:0] en_prev;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_prev <= '0;
      else         en_prev <= line_en_i;
   end

   // R1: reset values
   always_comb begin
      if (!rst_ni) begin
         p_reset_vals_r1: assert (!tx_ready_o && !tx_irq_o && tx_line_o == '0);
      end
   end

   // R2: ready rises only after a qualified tick
   p_rise_needs_scan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_ready_o) |-> $past(tick_i && scan_en_i && !rdy_clr_i));

   // R3: the reported line was enabled at search time
   p_hit_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_ready_o) |-> en_prev[tx_line_o]);

   // R4: an empty mask leaves state alone
   p_miss_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && scan_en_i && !tx_ready_o && !rdy_clr_i && line_en_i == '0)
      |=> (!tx_ready_o && $stable(tx_line_o)));

   // R6: interrupt follows the enable seen at the search
   p_irq_on_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_ready_o) |-> (tx_irq_o == $past(tx_int_en_i)));

   // R7: clear strobe drops ready and interrupt, keeps line
   p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdy_clr_i |=> (!tx_ready_o && !tx_irq_o && $stable(tx_line_o)));

   // R8: scan enable low drops ready and interrupt
   p_scan_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !scan_en_i |=> (!tx_ready_o && !tx_irq_o));

   // R9: receive slot only exists on a tick
   p_slot_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_slot_o |-> tick_i);

endmodule

// File: tb/test_lsc_tx_scanner.sv
module test_lsc_tx_scanner;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int LW         = 2;
   localparam int SEED       = 1234;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          scan_en = 1'b0;
   logic          ie = 1'b0;
   logic [N-1:0]  en = '0;
   logic          clr = 1'b0;
   logic          ready;
   logic [LW-1:0] line;
   logic          irq;
   logic          rx_slot;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // model state
   bit          m_ready = 0;
   bit          m_irq   = 0;
   int          m_last  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lsc_tx_scanner #(.NUM_LINES(N)) i_lsc_tx_scanner (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .scan_en_i   (scan_en),
      .tx_int_en_i (ie),
      .line_en_i   (en),
      .rdy_clr_i   (clr),
      .tx_ready_o  (ready),
      .tx_line_o   (line),
      .tx_irq_o    (irq),
      .rx_slot_o   (rx_slot)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // search order: last+1 ... last (wrapping), first enabled wins
   function automatic int pick(input int last, input logic [N-1:0] m);
      for (int i = 1; i <= N; i++) begin
         if (m[(last + i) % N]) return (last + i) % N;
      end
      return -1;
   endfunction

   // one cycle: drive at negedge, check comb slot, check regs next negedge
   task automatic step(input bit t, input bit se, input bit ien,
                       input logic [N-1:0] m, input bit c, input string tag);
      int  p;
      bit  go;
      bit  exp_slot;
      tick = t; scan_en = se; ie = ien; en = m; clr = c;
      #1;
      p  = pick(m_last, m);
      go = t && se && !m_ready && !c;
      exp_slot = t && !(go && p >= 0);
      chk(rx_slot == exp_slot, tag, "rx_slot (R9)", int'(rx_slot), int'(exp_slot));
      if (!se || c) begin
         m_ready = 0;
         m_irq   = 0;
      end else if (go && p >= 0) begin
         m_ready = 1;
         m_irq   = ien;
         m_last  = p;
      end
      @(posedge clk);
      @(negedge clk);
      chk(ready == m_ready, tag, "ready", int'(ready), int'(m_ready));
      chk(int'(line) == m_last, tag, "line", int'(line), m_last);
      chk(irq == m_irq, tag, "irq", int'(irq), int'(m_irq));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(SEED));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ready == 1'b0 && irq == 1'b0 && line == '0, "R1", "reset outputs",
          {ready, irq, line}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b0, "R1", "ready after release", int'(ready), 0);

      // R4: empty mask finds nothing, slot stays with receive
      step(1, 1, 1, 4'b0000, 0, "R4");
      // R3: only line 0 enabled, search wraps 1,2,3,0
      step(1, 1, 1, 4'b0001, 0, "R3");
      chk(line == 2'd0 && ready, "R3", "wrap to line 0", int'(line), 0);
      // R6: interrupt taken from enable
      chk(irq == 1'b1, "R6", "irq on hit", int'(irq), 1);
      // R5: further ticks while ready do nothing
      step(1, 1, 0, 4'b1111, 0, "R5");
      chk(line == 2'd0, "R5", "line held", int'(line), 0);
      // R7: clear drops ready and irq
      step(0, 1, 0, 4'b1111, 1, "R7");
      chk(!ready && !irq, "R7", "cleared", {ready, irq}, 0);
      // R3: round robin across all lines
      for (int k = 1; k <= 5; k++) begin
         step(1, 1, 0, 4'b1111, 0, "R3");
         chk(int'(line) == k % N, "R3", "round robin", int'(line), k % N);
         step(0, 1, 0, 4'b1111, 1, "R7");
      end
      // R3: only the served line enabled: it is picked again last
      step(1, 1, 1, 4'b0001 << m_last, 0, "R3");
      // R2: clear coinciding with tick blocks the search
      step(0, 1, 0, 4'b1111, 1, "R7");
      step(1, 1, 1, 4'b1111, 1, "R2");
      chk(ready == 1'b0, "R2", "clear blocks tick", int'(ready), 0);
      // R8: scan enable low while ready, and tick with scan off
      step(1, 1, 1, 4'b0100, 0, "R8");
      step(0, 0, 1, 4'b0100, 0, "R8");
      chk(!ready && !irq, "R8", "scan off clears", {ready, irq}, 0);
      step(1, 0, 1, 4'b1111, 0, "R8");
      // R10: irq never without ready (random mix checks irq vs model)
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 2) == 0, ($urandom % 8) != 0, ($urandom % 2) == 0,
              N'($urandom), ($urandom % 4) == 0, "R3");
         if (irq && !ready) chk(0, "R10", "irq without ready", int'(irq), 0);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule